// File: doc/BRIEF.md
# Dual Reloadable Interval Timer

Two independent countdown channels sit behind a small word-addressed register bus. Each channel holds a 32-bit reload word and a 32-bit control word. Once software enables a channel, it waits for an interval and then latches a sticky interrupt request into a shared 16-bit pending vector. The interval is either the reload value counted in cycles of the block clock, or one tick of a slow reference. A channel can expire once and stop, or keep restarting after each expiry.

The block runs on the fast system clock. The slow reference arrives as a one-cycle `slow_tick` enable in that same clock domain. Software acknowledges a request by writing any data to the channel's acknowledge address.

Each channel occupies four word addresses. `addr[3:2]` selects the channel and `addr[1:0]` selects the register: 0 is reload, 1 is control and 2 is acknowledge. Reads return the register one cycle after `rd_en`.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every reload and control read returns 0, `irq_pending` is 0, and no channel is counting.
- R2: A read of a channel's reload (offset 0) or control (offset 1) address returns the last written value on `rdata` one cycle after `rd_en`. Any other address reads 0, and `rdata` is 0 in every cycle that follows a cycle without `rd_en`.
- R3: When control bit 3 is clear, setting control bit 7 starts a countdown of N fast cycles, where N is the reload value. The request appears N clock edges after the write edge. A reload value of 0 behaves as N = 1.
- R4: When control bit 6 is clear, a channel expires once and then stops. When bit 6 is set, the channel expires again every N cycles after each expiry.
- R5: When control bit 3 is set, the interval ends at the first `slow_tick` pulse after the start edge. The request is latched at the edge that samples that pulse.
- R6: A control write that clears bit 7 cancels the countdown in progress, so no later request appears.
- R7: While a channel is enabled, a reload write with a different value restarts the countdown from the new value. Writing the value already stored leaves the running countdown untouched.
- R8: A control write that changes bit 6 but not bit 7 keeps the remaining time of the current countdown. Only the repeats that follow use the new mode.
- R9: An expiry of channel 0 sets `irq_pending[8]` and an expiry of channel 1 sets `irq_pending[9]`. The bits stay set until acknowledged, and all other bits of the vector read 0.
- R10: A write of any data to a channel's acknowledge address (offset 2) clears that channel's pending bit at the next edge. If an expiry of the same channel lands on that edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse marking a slow reference tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address: channel in [3:2], register in [1:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| irq_pending | output | 16 | Sticky interrupt request vector |

## Verification
A write takes effect at the clock edge that samples it. A fast-mode request therefore appears exactly N edges later, a slow-mode request at the edge that samples the tick, an acknowledge at the following edge, and read data one edge after `rd_en`. The bench drives and samples only on falling edges and counts whole cycles from each write's edge. Every timing check looks at the cycle just before the due edge, where the output must still be clear, and at the cycle just after it, where the output must be set. Restart, same-value reload and mode toggle cases are timed against the original countdown, so a wrong restart shows up as an early or late request.

// File: rtl/dit_pkg.sv
package dit_pkg;

   typedef enum logic [1:0] {
      REG_RELOAD = 2'd0,
      REG_CTRL   = 2'd1,
      REG_ACK    = 2'd2,
      REG_SPARE  = 2'd3
   } dit_reg_e;

   localparam int CTRL_EN_BIT   = 7;
   localparam int CTRL_REP_BIT  = 6;
   localparam int CTRL_SLOW_BIT = 3;

endpackage

// File: rtl/dit_channel.sv
module dit_channel
   import dit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              wr_reload,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reload_q,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              fire,
   output logic              running
);

   logic [DATA_W-1:0] cnt_q;
   logic              slow_mode_q;
   logic              reload_diff;
   logic              en_change;
   logic              restart_req;
   logic              new_enable;
   logic              new_slow;
   logic              new_rep;
   logic [DATA_W-1:0] new_reload;
   logic              expire;

   function automatic logic [DATA_W-1:0] fast_len(input logic [DATA_W-1:0] v);
      return (v == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : v;
   endfunction

   always_comb begin
      reload_diff = wr_reload && (wdata != reload_q);
      en_change   = wr_ctrl && (wdata[CTRL_EN_BIT] != ctrl_q[CTRL_EN_BIT]);
      restart_req = reload_diff || en_change;
      new_enable  = wr_ctrl ? wdata[CTRL_EN_BIT]   : ctrl_q[CTRL_EN_BIT];
      new_slow    = wr_ctrl ? wdata[CTRL_SLOW_BIT] : ctrl_q[CTRL_SLOW_BIT];
      new_rep     = wr_ctrl ? wdata[CTRL_REP_BIT]  : ctrl_q[CTRL_REP_BIT];
      new_reload  = wr_reload ? wdata : reload_q;
      expire      = slow_mode_q ? slow_tick : (cnt_q == {{(DATA_W-1){1'b0}}, 1'b1});
      fire        = running && !restart_req && expire;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         ctrl_q   <= '0;
      end else begin
         if (wr_reload) reload_q <= wdata;
         if (wr_ctrl)   ctrl_q   <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running     <= 1'b0;
         slow_mode_q <= 1'b0;
         cnt_q       <= '0;
      end else if (restart_req) begin
         running     <= new_enable;
         slow_mode_q <= new_slow;
         cnt_q       <= fast_len(new_reload);
      end else if (fire) begin
         running     <= new_rep;
         slow_mode_q <= new_slow;
         cnt_q       <= fast_len(reload_q);
      end else if (running && !slow_mode_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/dit_irq_vec.sv
module dit_irq_vec #(
   parameter int IRQ_W    = 16,
   parameter int IRQ_BASE = 8,
   parameter int NUM_CH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] fire,
   input  logic [NUM_CH-1:0] ack,
   output logic [IRQ_W-1:0]  pending
);

   for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
      if (b >= IRQ_BASE && b < IRQ_BASE + NUM_CH) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)                  pending[b] <= 1'b0;
            else if (fire[b - IRQ_BASE]) pending[b] <= 1'b1;
            else if (ack[b - IRQ_BASE])  pending[b] <= 1'b0;
         end
      end else begin : g_tied
         assign pending[b] = 1'b0;
      end
   end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int NUM_CH   = 2,
   parameter int IRQ_W    = 16,
   parameter int IRQ_BASE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [IRQ_W-1:0]  irq_pending
);

   localparam int CH_SEL_W = ADDR_W - 2;

   if (CH_SEL_W < 1 || NUM_CH > (1 << CH_SEL_W)) begin : g_bad_addr
      $error("dual_interval_timer: ADDR_W too small for NUM_CH");
   end
   if (IRQ_BASE + NUM_CH > IRQ_W) begin : g_bad_irq
      $error("dual_interval_timer: request bits exceed IRQ_W");
   end
   if (DATA_W <= CTRL_EN_BIT) begin : g_bad_data
      $error("dual_interval_timer: DATA_W too narrow for control bits");
   end

   logic [CH_SEL_W-1:0] ch_sel;
   dit_reg_e            reg_sel;
   logic [NUM_CH-1:0]   fire_vec;
   logic [NUM_CH-1:0]   run_vec;
   logic [NUM_CH-1:0]   ack_vec;
   logic [DATA_W-1:0]   reload_arr [NUM_CH];
   logic [DATA_W-1:0]   ctrl_arr   [NUM_CH];
   logic [DATA_W-1:0]   rd_mux;

   assign ch_sel  = addr[ADDR_W-1:2];
   assign reg_sel = dit_reg_e'(addr[1:0]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit        = wr_en && (ch_sel == CH_SEL_W'(c));
      assign ack_vec[c] = hit && (reg_sel == REG_ACK);

      dit_channel #(.DATA_W(DATA_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .slow_tick (slow_tick),
         .wr_reload (hit && (reg_sel == REG_RELOAD)),
         .wr_ctrl   (hit && (reg_sel == REG_CTRL)),
         .wdata     (wdata),
         .reload_q  (reload_arr[c]),
         .ctrl_q    (ctrl_arr[c]),
         .fire      (fire_vec[c]),
         .running   (run_vec[c])
      );
   end

   dit_irq_vec #(
      .IRQ_W    (IRQ_W),
      .IRQ_BASE (IRQ_BASE),
      .NUM_CH   (NUM_CH)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire_vec),
      .ack     (ack_vec),
      .pending (irq_pending)
   );

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_sel == CH_SEL_W'(c)) begin
            if (reg_sel == REG_RELOAD)    rd_mux = reload_arr[c];
            else if (reg_sel == REG_CTRL) rd_mux = ctrl_arr[c];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
      else            rdata <= '0;
   end

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int NUM_CH   = 2,
   parameter int IRQ_W    = 16,
   parameter int IRQ_BASE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en_bit,
   input logic [DATA_W-1:0] rdata,
   input logic [IRQ_W-1:0]  irq_pending,
   input logic [NUM_CH-1:0] fire,
   input logic [NUM_CH-1:0] run
);

   // R2: idle read port returns zero
   a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      logic ack_wr;
      logic ctrl_wr;
      assign ack_wr  = wr_en && (addr == ADDR_W'((c << 2) | 2));
      assign ctrl_wr = wr_en && (addr == ADDR_W'((c << 2) | 1));

      // R9: an expiry latches the request
      a_r9_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
         fire[c] |=> irq_pending[IRQ_BASE + c]);

      // R9: a request holds until acknowledged
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_pending[IRQ_BASE + c] && !ack_wr) |=> irq_pending[IRQ_BASE + c]);

      // R10: acknowledge clears when no expiry collides
      a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_wr && !fire[c]) |=> !irq_pending[IRQ_BASE + c]);

      // R6: clearing the enable bit stops the channel
      a_r6_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_wr && !wr_en_bit) |=> !run[c]);

      // R7: an idle channel only starts on a write
      a_r7_idle_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
         (!run[c] && !wr_en) |=> !run[c]);

      // R4: only a counting channel can expire
      a_r4_fire_only_running: assert property (@(posedge clk) disable iff (!rst_n)
         fire[c] |-> run[c]);
   end

endmodule

bind dual_interval_timer dit_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_CH   (NUM_CH),
   .IRQ_W    (IRQ_W),
   .IRQ_BASE (IRQ_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .addr        (addr),
   .wr_en_bit   (wdata[dit_pkg::CTRL_EN_BIT]),
   .rdata       (rdata),
   .irq_pending (irq_pending),
   .fire        (fire_vec),
   .run         (run_vec)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] irq_pending;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   localparam logic [3:0] A0_RLD = 4'd0, A0_CTL = 4'd1, A0_ACK = 4'd2;
   localparam logic [3:0] A1_RLD = 4'd4, A1_CTL = 4'd5, A1_ACK = 4'd6;

   always #4 clk = ~clk;

   dual_interval_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .slow_tick   (slow_tick),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wdata       (wdata),
      .rdata       (rdata),
      .irq_pending (irq_pending)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0; addr = '0;
      d = rdata;
   endtask

   task automatic tick_slow();
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 pending after reset", {16'd0, irq_pending}, 32'd0);
      bus_rd(A0_RLD, d); chk("R1 reload0 reset", d, 32'd0);
      bus_rd(A1_CTL, d); chk("R1 ctrl1 reset", d, 32'd0);
      step(20);
      chk("R1 idle no request", {16'd0, irq_pending}, 32'd0);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      bus_wr(A0_RLD, 32'h1234_5678);
      bus_wr(A1_CTL, 32'h0000_0048);
      bus_rd(A0_RLD, d); chk("R2 reload0 readback", d, 32'h1234_5678);
      bus_rd(A1_CTL, d); chk("R2 ctrl1 readback", d, 32'h0000_0048);
      bus_rd(4'd3, d);   chk("R2 unmapped reads zero", d, 32'd0);
      chk("R2 rdata zero after read", rdata, 32'd0);
      bus_wr(A1_CTL, 32'd0);
   endtask

   task automatic t_fast_oneshot();
      bus_wr(A0_RLD, 32'd5);
      bus_wr(A0_CTL, 32'h80);
      step(4); chk("R3 not yet at N-1", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R3 request at N", {31'd0, irq_pending[8]}, 32'd1);
      chk("R9 ch0 maps to bit 8 only", {16'd0, irq_pending}, 32'h0000_0100);
      bus_wr(A0_ACK, 32'd0);
      chk("R10 ack clears bit 8", {31'd0, irq_pending[8]}, 32'd0);
      step(12); chk("R4 one-shot fires once", {31'd0, irq_pending[8]}, 32'd0);
      bus_wr(A0_CTL, 32'd0);
   endtask

   task automatic t_zero_reload();
      bus_wr(A0_RLD, 32'd0);
      bus_wr(A0_CTL, 32'h80);
      chk("R3 zero reload clear at k0", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R3 zero reload acts as 1", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_CTL, 32'd0);
      bus_wr(A0_ACK, 32'hFFFF_FFFF);
   endtask

   task automatic t_periodic_and_disable();
      bus_wr(A0_RLD, 32'd3);
      bus_wr(A0_CTL, 32'hC0);
      step(2); chk("R4 periodic clear at k2", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R4 periodic first at k3", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_ACK, 32'd0);
      chk("R4 cleared at k4", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R4 clear at k5", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R4 repeat at k6", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_CTL, 32'h40);
      bus_wr(A0_ACK, 32'd0);
      step(8); chk("R6 disable cancels", {31'd0, irq_pending[8]}, 32'd0);
   endtask

   task automatic t_slow();
      bus_wr(A1_CTL, 32'h88);
      step(5); chk("R5 waits for tick", {31'd0, irq_pending[9]}, 32'd0);
      tick_slow();
      chk("R5 request on tick", {31'd0, irq_pending[9]}, 32'd1);
      chk("R9 ch1 maps to bit 9 only", {16'd0, irq_pending}, 32'h0000_0200);
      bus_wr(A1_ACK, 32'h5A);
      tick_slow();
      chk("R5 one-shot slow stops", {31'd0, irq_pending[9]}, 32'd0);
      bus_wr(A1_CTL, 32'd0);
   endtask

   task automatic t_reload_rewrite();
      bus_wr(A0_RLD, 32'd8);
      bus_wr(A0_CTL, 32'h80);
      step(4);
      bus_wr(A0_RLD, 32'd8);
      step(2); chk("R7 same value k7", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R7 same value keeps k8", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_CTL, 32'd0);
      bus_wr(A0_ACK, 32'd0);
      bus_wr(A0_CTL, 32'h80);
      step(4);
      bus_wr(A0_RLD, 32'd6);
      step(3); chk("R7 old expiry dropped k8", {31'd0, irq_pending[8]}, 32'd0);
      step(2); chk("R7 new clear k10", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R7 restart fires k11", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_CTL, 32'd0);
      bus_wr(A0_ACK, 32'd0);
   endtask

   task automatic t_toggle_periodic();
      bus_wr(A0_CTL, 32'h80);
      step(2);
      bus_wr(A0_CTL, 32'hC0);
      step(2); chk("R8 clear at k5", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R8 remaining kept k6", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_ACK, 32'd0);
      step(4); chk("R8 repeat clear k11", {31'd0, irq_pending[8]}, 32'd0);
      step(1); chk("R8 now repeats k12", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_CTL, 32'd0);
      bus_wr(A0_ACK, 32'd0);
   endtask

   task automatic t_ack_collision();
      bus_wr(A0_RLD, 32'd2);
      bus_wr(A0_CTL, 32'hC0);
      step(3);
      bus_wr(A0_ACK, 32'd0);
      chk("R10 expiry wins over ack", {31'd0, irq_pending[8]}, 32'd1);
      bus_wr(A0_CTL, 32'd0);
      bus_wr(A0_ACK, 32'd0);
      chk("R10 final ack clears", {16'd0, irq_pending}, 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_fast_oneshot();
      t_zero_reload();
      t_periodic_and_disable();
      t_slow();
      t_reload_rewrite();
      t_toggle_periodic();
      t_ack_collision();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule